// File: doc/BRIEF.md
# Divide-by-320 Timebase with Exact Half-Period Output

This block turns a 32000 Hz reference strobe into a 100 Hz timing signal whose high and low phases are exactly equal. An 8-bit binary counter advances once per reference strobe. When the incremented value would show bits 7 and 5 both set (160), the counter returns to 0 on that same clock edge. The counter therefore cycles through 160 states (128 + 32). Its top bit is a 200 Hz level that is high for 32 strobes and low for 128. A toggle stage flips on every rising edge of that bit. This halves the rate to 100 Hz and evens the duty to 50%. An equal duty matters downstream because a run gate that opens and closes at unrelated times samples this signal.

The design runs on a single system clock, and `ref_tick` is a one-cycle enable at the reference rate. In external mode the internal divider is held cleared. Each external 200 Hz strobe then drives the toggle stage directly. A one-clock pulse marks each falling edge of the 100 Hz level. This pulse is the point where a falling-edge counter further down the chain would advance.

Top module: `timebase_div320`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, `out_200`, `out_100` and `tick_100` all become 0.
- R2: In internal mode (`ext_mode` = 0), the counter advances by one only on edges where `ref_tick` is 1, and it holds otherwise. `out_200` equals counter bit 7, so it is high while the count is 128 to 159.
- R3: The count never shows 160. The strobe that moves it past 159 returns it to 0, so after reset 160 continuous strobes give exactly 32 cycles of `out_200` high.
- R4: `out_100` inverts on the same edge at which `out_200` rises (count 127 to 128), and at no other edge in internal mode. With continuous strobes from reset, `out_100` is high for 320 of the first 640 cycles.
- R5: `tick_100` is 1 for exactly one cycle, namely the first cycle in which `out_100` reads 0 after reading 1.
- R6: In external mode (`ext_mode` = 1), the counter is forced to 0 and `out_200` is low, and `ref_tick` has no effect. Each edge with `ext_tick` = 1 inverts `out_100`.
- R7: In internal mode, `ext_tick` has no effect on any output.
- R8: A reset in the middle of a run restarts the sequence from count 0 with `out_100` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe at the reference rate |
| ext_mode | input | 1 | 1 = bypass the divider and use ext_tick |
| ext_tick | input | 1 | One-cycle external 200 Hz strobe |
| out_200 | output | 1 | Counter top bit (200 Hz level) |
| out_100 | output | 1 | 50% duty 100 Hz level |
| tick_100 | output | 1 | One-cycle pulse at each falling edge of out_100 |

## Verification
The first pattern is a continuous strobe straight after reset. Its high-cycle counts over 640 cycles separate a correct 160-state wrap from an off-by-one modulus or a wrong toggle edge. The second is random sparse strobes in internal mode with random `ext_tick` noise, which shows whether the counter holds between strobes and ignores the external input. Random external-mode stretches with stray `ref_tick` show whether the counter is cleared and the bypass toggles correctly. A reset in the middle of a run shows whether the sequence restarts cleanly from 0.

// File: rtl/timebase_pkg.sv
// Shared definitions for the divide-by-320 timebase.
// Assumes: nothing beyond IEEE 1800-2017.
package timebase_pkg;
    typedef enum logic {
        SRC_DIVIDER  = 1'b0,
        SRC_EXTERNAL = 1'b1
    } tb_src_e;
endpackage

// File: rtl/tbd_mod_counter.sv
// Truncated binary up-counter. The increment is compared against the bit
// pattern of MODULUS and cleared on the same edge, so the count spans
// 0..MODULUS-1. Reports the edge at which the top bit rises.
// Assumes: no value below MODULUS carries every set bit of MODULUS.
module tbd_mod_counter #(
    parameter int CNT_W   = 8,
    parameter int MODULUS = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [CNT_W-1:0] count,
    output logic             msb_rise
);
    localparam logic [CNT_W-1:0] MATCH = CNT_W'(MODULUS);
    localparam int               TOP   = CNT_W - 1;

    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] nxt;
    logic             hit;

    // Form the next count and detect the truncation pattern.
    always_comb begin
        inc = count + 1'b1;
        hit = ((inc & MATCH) == MATCH);
        nxt = hit ? '0 : inc;
    end

    // The top bit is about to rise on this advancing edge.
    assign msb_rise = adv & ~clr & ~count[TOP] & nxt[TOP];

    // Count register with synchronous reset and mode clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (adv) count <= nxt;
    end
endmodule

// File: rtl/tbd_toggle_stage.sv
// Toggle flip-flop with a one-cycle marker for its 1->0 transitions.
// Assumes: flip is a single-cycle enable in the clk domain.
module tbd_toggle_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic level,
    output logic fall_tick
);
    // Invert on each flip and flag the edges that take it low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level     <= 1'b0;
            fall_tick <= 1'b0;
        end else begin
            level     <= level ^ flip;
            fall_tick <= flip & level;
        end
    end
endmodule

// File: rtl/timebase_div320.sv
// Divide-by-320 timebase: a modulus-160 counter gives the 200 Hz level, and
// a toggle stage halves it to an exact 50% duty 100 Hz level. External mode
// clears the counter and steers ext_tick into the toggle stage.
// Assumes: ref_tick and ext_tick are one-cycle enables in the clk domain.
module timebase_div320 #(
    parameter int CNT_W   = 8,
    parameter int MODULUS = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic ext_mode,
    input  logic ext_tick,
    output logic out_200,
    output logic out_100,
    output logic tick_100
);
    import timebase_pkg::*;

    tb_src_e          src;
    logic [CNT_W-1:0] cnt_q;
    logic             rise_200;
    logic             flip;

    // Decode the toggle source.
    always_comb begin
        src  = ext_mode ? SRC_EXTERNAL : SRC_DIVIDER;
        flip = (src == SRC_EXTERNAL) ? ext_tick : rise_200;
    end

    tbd_mod_counter #(.CNT_W(CNT_W), .MODULUS(MODULUS)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (src == SRC_EXTERNAL),
        .adv      (ref_tick),
        .count    (cnt_q),
        .msb_rise (rise_200)
    );

    tbd_toggle_stage i_tgl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flip      (flip),
        .level     (out_100),
        .fall_tick (tick_100)
    );

    assign out_200 = cnt_q[CNT_W-1];
endmodule

// File: rtl/timebase_div320_chk.sv
// Property checker for timebase_div320, attached by bind.
module timebase_div320_chk #(
    parameter int CNT_W   = 8,
    parameter int MODULUS = 160
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_tick,
    input logic             ext_mode,
    input logic             ext_tick,
    input logic             out_200,
    input logic             out_100,
    input logic             tick_100,
    input logic [CNT_W-1:0] cnt_q
);
    assert_below_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MODULUS));
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && !ext_mode) |=> $stable(cnt_q));
    assert_toggle_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_200) |-> (out_100 != $past(out_100)));
    assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_100 |=> !tick_100);
    assert_tick_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_100 |-> (!out_100 && $past(out_100)));
    assert_ext_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |=> (cnt_q == '0 && !out_200));
    assert_ext_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && !ref_tick) |=> $stable(out_100));
endmodule

bind timebase_div320 timebase_div320_chk #(.CNT_W(CNT_W), .MODULUS(MODULUS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .ext_mode (ext_mode),
    .ext_tick (ext_tick),
    .out_200  (out_200),
    .out_100  (out_100),
    .tick_100 (tick_100),
    .cnt_q    (cnt_q)
);

// File: tb/test_timebase_div320.sv
module test_timebase_div320;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic ext_mode = 1'b0;
    logic ext_tick = 1'b0;
    logic out_200, out_100, tick_100;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int   m_cnt = 0;
    logic m_lvl = 1'b0;
    logic m_tick = 1'b0;

    // window statistics
    int hi200 = 0, hi100 = 0, nticks = 0;

    always #4 clk = ~clk;

    timebase_div320 i_timebase_div320 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ext_mode(ext_mode),
        .ext_tick(ext_tick), .out_200(out_200), .out_100(out_100), .tick_100(tick_100)
    );

    function automatic int next_count(int c);
        return (c == 159) ? 0 : c + 1;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle, update the model, then compare after the edge.
    task automatic step(logic rn, logic rt, logic em, logic et, string req);
        logic flip;
        rst_n = rn; ref_tick = rt; ext_mode = em; ext_tick = et;
        if (!rn) begin
            m_cnt = 0; m_lvl = 1'b0; m_tick = 1'b0;
        end else begin
            if (em) begin
                flip = et;
                m_cnt = 0;
            end else begin
                flip = rt && (m_cnt == 127);
                if (rt) m_cnt = next_count(m_cnt);
            end
            m_tick = flip && m_lvl;
            m_lvl = m_lvl ^ flip;
        end
        @(posedge clk);
        @(negedge clk);
        check(req, "out_200", int'(out_200), int'(m_cnt >= 128));
        check(req, "out_100", int'(out_100), int'(m_lvl));
        check(req, "tick_100", int'(tick_100), int'(m_tick));
        hi200 += int'(out_200);
        hi100 += int'(out_100);
        nticks += int'(tick_100);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b1, "R1");

        // R3, R4: continuous strobes from reset over two full periods
        hi200 = 0; hi100 = 0; nticks = 0;
        for (int i = 0; i < 640; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R3");
        check("R3", "out_200 high cycles", hi200, 128);
        check("R4", "out_100 high cycles", hi100, 320);
        check("R5", "tick_100 pulses", nticks, 2);

        // R2, R7: sparse random strobes with ext_tick noise
        for (int i = 0; i < 4000; i++)
            step(1'b1, logic'($urandom_range(0, 2) == 0), 1'b0,
                 logic'($urandom_range(0, 1)), "R7");

        // R6: external mode with stray ref_tick
        for (int i = 0; i < 600; i++)
            step(1'b1, logic'($urandom_range(0, 1)), 1'b1,
                 logic'($urandom_range(0, 3) == 0), "R6");

        // R2: back to the divider, dense strobes
        for (int i = 0; i < 2000; i++)
            step(1'b1, logic'($urandom_range(0, 3) != 0), 1'b0, 1'b0, "R2");

        // R8: mid-run reset then restart with continuous strobes
        for (int i = 0; i < 200; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R8");
        check("R8", "out_100 after reset", int'(out_100), 0);
        hi200 = 0;
        for (int i = 0; i < 160; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        check("R8", "out_200 high cycles after restart", hi200, 32);

        // R6: mode entry while count nonzero clears immediately
        for (int i = 0; i < 140; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R6");
        check("R6", "out_200 in external mode", int'(out_200), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule